// File: doc/BRIEF.md
# Bridge Configuration Header Register File

This block holds the configuration header of a PCI-to-PCI bridge and serves it to a configuration access port. A read returns a whole dword, chosen by the upper bits of the byte offset. A write may cover one byte, two bytes or four bytes. The block takes the dword's current contents and replaces only the addressed bytes. It then applies the write-protection rules of the header before it stores the result.

The identity, class and header-type dwords are fixed. Command and status, the two BARs, the bus-number dword, the I/O window, the memory window, the prefetchable window and the upper-address dwords can all be written. The block passes the secondary bus number and the raw window fields to neighbouring logic. It also sends a one-cycle strobe whenever an I/O or memory window field changes, so that the window decoders can recompute their ranges.

Each access is answered with a response one clock cycle later.

Top module: `cfgb_hdr`

## Requirements
- R1: After reset, the header reads as follows:
  - dword 0x00 reads {DEVICE_ID, VENDOR_ID}.
  - 0x04 reads 0x00100000 (the capability-list status bit is set).
  - 0x08 reads 0x06040000 (bridge class).
  - 0x0C reads 0x00010010 (header type 1, cache line 0x10).
  - 0x1C reads 0x00000101.
  - Every other mapped dword reads 0.
- R2: Dword 0x18 reads {secondary latency, subordinate bus, secondary bus, primary bus} from byte 3 down to byte 0. Dword 0x1C reads {secondary status[31:16], I/O limit[15:8], I/O base[7:0]}. Writes to both dwords are stored and read back.
- R3: Dword 0x20 holds {memory limit, memory base}, 0x24 holds the prefetchable pair, 0x28 holds the upper prefetchable base, 0x2C holds the upper prefetchable limit, and 0x30 holds {I/O limit upper, I/O base upper}. The window outputs always equal these stored dwords. Dword 0x38 always reads 0.
- R4: An access to dword 0x34, to 0x3C, or to any offset of 0x40 or above is answered with the error flag set. A read there returns 0xFFFFFFFF, and a write there changes nothing.
- R5: The access length code is 0 for a byte, 1 for two bytes and 2 for a dword. A write replaces only the bytes from offset[1:0] upward that the length covers; all other bytes of the dword are kept. The data is taken from the low bits of the write data and shifted left by 8 × offset[1:0]. Bits above the access width are ignored.
- R6: Bit 0 of the I/O base byte and bit 0 of the I/O limit byte (bits 0 and 8 of dword 0x1C) always read 1, whatever is written to them.
- R7: Writes to dwords 0x00, 0x08, 0x0C and 0x38 leave their contents unchanged, and the response carries no error.
- R8: The secondary bus output equals byte 1 of dword 0x18. It changes only after a write to that dword.
- R9: The I/O change strobe is high for exactly the one cycle after an accepted write to 0x1C or 0x30. The memory change strobe is high for the one cycle after an accepted write to 0x20. Neither strobe rises at any other time.
- R10: The response valid flag is high exactly one cycle after each access. A write returns data 0. A write with length code 3 returns the error flag and changes nothing. A read ignores the length code and offset[1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| acc_valid_i | input | 1 | Access request this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_off_i | input | OFF_W | Byte offset in the header |
| acc_len_i | input | 2 | Write length code (0 byte, 1 two bytes, 2 dword) |
| acc_wdata_i | input | 32 | Write data, right-aligned |
| rsp_valid_o | output | 1 | Response valid, one cycle after the access |
| rsp_data_o | output | 32 | Read data |
| rsp_err_o | output | 1 | Unmapped offset or bad length |
| sec_bus_o | output | 8 | Secondary bus number |
| io_win_o | output | 16 | {I/O limit, I/O base} |
| io_upper_o | output | 32 | {I/O limit upper, I/O base upper} |
| mem_win_o | output | 32 | {memory limit, memory base} |
| pref_win_o | output | 32 | {prefetchable limit, prefetchable base} |
| pref_base_hi_o | output | 32 | Upper prefetchable base |
| pref_lim_hi_o | output | 32 | Upper prefetchable limit |
| io_chg_o | output | 1 | I/O window fields changed |
| mem_chg_o | output | 1 | Memory window fields changed |

## Verification
The bench targets partial writes at every byte position, including a two-byte write at offset 3. A design that drops the read-modify-write step would clear the neighbouring bytes, and one that shifts the data wrongly would land it in the wrong lane. Writes to 0x1C that clear bit 0 check the forced I/O type bits; a design that stores the value as written would report 16-bit I/O decoding. Writes and reads at the hole at 0x34, above 0x3C and with length code 3 expose a decoder that aliases or accepts them, because the state would change or the error flag would stay low. Fully written read-only dwords and the strobe checks catch state that moves, or strobes that fire, on the wrong offset.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

  typedef enum logic [1:0] {
    LEN_BYTE = 2'd0,
    LEN_HALF = 2'd1,
    LEN_WORD = 2'd2,
    LEN_BAD  = 2'd3
  } acc_len_e;

  localparam int DW_BITS = 32;
  localparam int NUM_DW  = 13;          // stored dword slots 0x00..0x30
  localparam int IDX_ID    = 0;
  localparam int IDX_CMD   = 1;
  localparam int IDX_CLASS = 2;
  localparam int IDX_HDR   = 3;
  localparam int IDX_BAR0  = 4;
  localparam int NUM_BAR   = 2;
  localparam int IDX_BUS   = 6;
  localparam int IDX_IO    = 7;
  localparam int IDX_MEM   = 8;
  localparam int IDX_PREF  = 9;
  localparam int IDX_PBHI  = 10;
  localparam int IDX_PLHI  = 11;
  localparam int IDX_IOUP  = 12;
  localparam int IDX_CAP   = 13;        // unmapped hole
  localparam int IDX_ROM   = 14;        // reads zero

  localparam logic [31:0] IO_TYPE32 = 32'h0000_0101;

  function automatic bit dw_writable(input int i);
    return (i == IDX_CMD) || (i >= IDX_BAR0 && i <= IDX_IOUP);
  endfunction

  function automatic logic [31:0] dw_reset(input int i, input logic [15:0] vid,
                                           input logic [15:0] did);
    case (i)
      IDX_ID:    return {did, vid};
      IDX_CMD:   return 32'h0010_0000;
      IDX_CLASS: return 32'h0604_0000;
      IDX_HDR:   return 32'h0001_0010;
      IDX_IO:    return IO_TYPE32;
      default:   return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/cfgb_merge.sv
module cfgb_merge
  import cfgb_pkg::*;
(
  input  logic [31:0] old_i,
  input  logic [31:0] wdata_i,
  input  acc_len_e    len_i,
  input  logic [1:0]  lo_i,
  output logic [31:0] merged_o,
  output logic        len_ok_o
);
  logic [31:0] width_mask;
  logic [31:0] lane_mask;
  logic [31:0] placed;

  always_comb begin
    len_ok_o = 1'b1;
    case (len_i)
      LEN_BYTE: width_mask = 32'h0000_00FF;
      LEN_HALF: width_mask = 32'h0000_FFFF;
      LEN_WORD: width_mask = 32'hFFFF_FFFF;
      default: begin
        width_mask = 32'h0;
        len_ok_o   = 1'b0;
      end
    endcase
    lane_mask = width_mask << {lo_i, 3'b000};
    placed    = (wdata_i & width_mask) << {lo_i, 3'b000};
    merged_o  = (old_i & ~lane_mask) | (placed & lane_mask);
  end
endmodule

// File: rtl/cfgb_rdmux.sv
module cfgb_rdmux
  import cfgb_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int NDW   = NUM_DW
) (
  input  logic [31:0]      dw_i [NDW],
  input  logic [IDX_W-1:0] idx_i,
  output logic [31:0]      rdata_o,
  output logic             hit_o
);
  always_comb begin
    hit_o   = 1'b0;
    rdata_o = 32'hFFFF_FFFF;
    for (int k = 0; k < NDW; k++) begin
      if (idx_i == IDX_W'(k)) begin
        hit_o   = 1'b1;
        rdata_o = dw_i[k];
      end
    end
    if (idx_i == IDX_W'(IDX_ROM)) begin
      hit_o   = 1'b1;
      rdata_o = 32'h0;
    end
  end
endmodule

// File: rtl/cfgb_hdr.sv
module cfgb_hdr
  import cfgb_pkg::*;
#(
  parameter int          OFF_W     = 8,
  parameter logic [15:0] VENDOR_ID = 16'h1AB3,
  parameter logic [15:0] DEVICE_ID = 16'h2C05
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid_i,
  input  logic             acc_write_i,
  input  logic [OFF_W-1:0] acc_off_i,
  input  logic [1:0]       acc_len_i,
  input  logic [31:0]      acc_wdata_i,
  output logic             rsp_valid_o,
  output logic [31:0]      rsp_data_o,
  output logic             rsp_err_o,
  output logic [7:0]       sec_bus_o,
  output logic [15:0]      io_win_o,
  output logic [31:0]      io_upper_o,
  output logic [31:0]      mem_win_o,
  output logic [31:0]      pref_win_o,
  output logic [31:0]      pref_base_hi_o,
  output logic [31:0]      pref_lim_hi_o,
  output logic             io_chg_o,
  output logic             mem_chg_o
);
  localparam int IDX_W = OFF_W - 2;

  logic [IDX_W-1:0] idx;
  logic [31:0]      dw [NUM_DW];
  logic [31:0]      rd_word;
  logic             hit;
  logic [31:0]      merged;
  logic             len_ok;
  logic             wr_ok;
  logic [31:0]      wval;

  // response and strobe state
  logic        rsp_valid_q, rsp_valid_d;
  logic [31:0] rsp_data_q,  rsp_data_d;
  logic        rsp_err_q,   rsp_err_d;
  logic        io_chg_q,    io_chg_d;
  logic        mem_chg_q,   mem_chg_d;

  assign idx = acc_off_i[OFF_W-1:2];

  cfgb_rdmux #(.IDX_W(IDX_W), .NDW(NUM_DW)) i_rdmux (
    .dw_i    (dw),
    .idx_i   (idx),
    .rdata_o (rd_word),
    .hit_o   (hit)
  );

  cfgb_merge i_merge (
    .old_i    (rd_word),
    .wdata_i  (acc_wdata_i),
    .len_i    (acc_len_e'(acc_len_i)),
    .lo_i     (acc_off_i[1:0]),
    .merged_o (merged),
    .len_ok_o (len_ok)
  );

  // next-state: write acceptance and stored value
  always_comb begin
    wr_ok = acc_valid_i && acc_write_i && hit && len_ok;
    wval  = merged;
    if (idx == IDX_W'(IDX_IO)) wval = merged | IO_TYPE32;
  end

  for (genvar g = 0; g < NUM_DW; g++) begin : g_dw
    localparam logic [31:0] RST_VAL = dw_reset(g, VENDOR_ID, DEVICE_ID);
    if (dw_writable(g)) begin : g_rw
      logic [31:0] q;
      logic        en;
      assign en = wr_ok && (idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= RST_VAL;
        else if (en) q <= wval;
      end
      assign dw[g] = q;
    end else begin : g_ro
      assign dw[g] = RST_VAL;
    end
  end

  always_comb begin
    rsp_valid_d = acc_valid_i;
    rsp_err_d   = acc_valid_i && (!hit || (acc_write_i && !len_ok));
    rsp_data_d  = (acc_valid_i && !acc_write_i) ? rd_word : 32'h0;
    io_chg_d    = wr_ok && ((idx == IDX_W'(IDX_IO)) || (idx == IDX_W'(IDX_IOUP)));
    mem_chg_d   = wr_ok && (idx == IDX_W'(IDX_MEM));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= 32'h0;
      rsp_err_q   <= 1'b0;
      io_chg_q    <= 1'b0;
      mem_chg_q   <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_data_q  <= rsp_data_d;
      rsp_err_q   <= rsp_err_d;
      io_chg_q    <= io_chg_d;
      mem_chg_q   <= mem_chg_d;
    end
  end

  assign rsp_valid_o    = rsp_valid_q;
  assign rsp_data_o     = rsp_data_q;
  assign rsp_err_o      = rsp_err_q;
  assign io_chg_o       = io_chg_q;
  assign mem_chg_o      = mem_chg_q;
  assign sec_bus_o      = dw[IDX_BUS][15:8];
  assign io_win_o       = dw[IDX_IO][15:0];
  assign io_upper_o     = dw[IDX_IOUP];
  assign mem_win_o      = dw[IDX_MEM];
  assign pref_win_o     = dw[IDX_PREF];
  assign pref_base_hi_o = dw[IDX_PBHI];
  assign pref_lim_hi_o  = dw[IDX_PLHI];

endmodule

// File: rtl/cfgb_hdr_chk.sv
module cfgb_hdr_chk #(
  parameter int OFF_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid_i,
  input logic             acc_write_i,
  input logic [OFF_W-1:0] acc_off_i,
  input logic             rsp_valid_o,
  input logic [31:0]      rsp_data_o,
  input logic             rsp_err_o,
  input logic [7:0]       sec_bus_o,
  input logic [15:0]      io_win_o,
  input logic             io_chg_o,
  input logic             mem_chg_o
);
  logic bus_wr;
  logic high_rd;
  assign bus_wr  = acc_valid_i && acc_write_i && (acc_off_i[OFF_W-1:2] == (OFF_W-2)'(6));
  assign high_rd = acc_valid_i && !acc_write_i && (acc_off_i >= OFF_W'(8'h40));

  // R10
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_i |=> rsp_valid_o);

  // R10
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid_i |=> !rsp_valid_o);

  // R4
  high_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    high_rd |=> (rsp_err_o && rsp_data_o == 32'hFFFF_FFFF));

  // R6
  io_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_win_o[0] && io_win_o[8]);

  // R8
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(sec_bus_o));

  // R9
  io_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_chg_o |-> $past(acc_valid_i && acc_write_i));

  // R9
  mem_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_chg_o |-> $past(acc_valid_i && acc_write_i));
endmodule

bind cfgb_hdr cfgb_hdr_chk #(.OFF_W(OFF_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid_i (acc_valid_i),
  .acc_write_i (acc_write_i),
  .acc_off_i   (acc_off_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_data_o  (rsp_data_o),
  .rsp_err_o   (rsp_err_o),
  .sec_bus_o   (sec_bus_o),
  .io_win_o    (io_win_o),
  .io_chg_o    (io_chg_o),
  .mem_chg_o   (mem_chg_o)
);

// File: tb/test_cfgb_hdr.sv
module test_cfgb_hdr;
  localparam logic [15:0] VID = 16'h1AB3;
  localparam logic [15:0] DID = 16'h2C05;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid_i, acc_write_i;
  logic [7:0]  acc_off_i;
  logic [1:0]  acc_len_i;
  logic [31:0] acc_wdata_i;
  logic        rsp_valid_o, rsp_err_o, io_chg_o, mem_chg_o;
  logic [31:0] rsp_data_o, io_upper_o, mem_win_o, pref_win_o, pref_base_hi_o, pref_lim_hi_o;
  logic [7:0]  sec_bus_o;
  logic [15:0] io_win_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] m [16];

  always #2 clk = ~clk;

  cfgb_hdr i_cfgb_hdr (
    .clk(clk), .rst_n(rst_n), .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i),
    .acc_off_i(acc_off_i), .acc_len_i(acc_len_i), .acc_wdata_i(acc_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o), .rsp_err_o(rsp_err_o),
    .sec_bus_o(sec_bus_o), .io_win_o(io_win_o), .io_upper_o(io_upper_o),
    .mem_win_o(mem_win_o), .pref_win_o(pref_win_o), .pref_base_hi_o(pref_base_hi_o),
    .pref_lim_hi_o(pref_lim_hi_o), .io_chg_o(io_chg_o), .mem_chg_o(mem_chg_o)
  );

  function automatic bit mapped(input int i);
    return (i < 15) && (i != 13);
  endfunction

  function automatic bit wable(input int i);
    return (i == 1) || (i >= 4 && i <= 12);
  endfunction

  function automatic logic [31:0] merge_exp(input logic [31:0] old, input logic [31:0] d,
                                            input int lo, input int nb);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++)
      if (b >= lo && b < lo + nb) r[8*b +: 8] = d[8*(b-lo) +: 8];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m[i] = 32'h0;
    m[0] = {DID, VID};
    m[1] = 32'h0010_0000;
    m[2] = 32'h0604_0000;
    m[3] = 32'h0001_0010;
    m[7] = 32'h0000_0101;
  endtask

  task automatic acc(input string tag, input bit wr, input logic [7:0] off,
                     input logic [1:0] len, input logic [31:0] d);
    int i = int'(off[7:2]);
    bit ok_len = (len != 2'd3);
    bit err_e  = !mapped(i) || (wr && !ok_len);
    bit wr_ok  = wr && mapped(i) && ok_len;
    logic [31:0] rd_e = !mapped(i) ? 32'hFFFF_FFFF : m[i];
    @(negedge clk);
    acc_valid_i = 1'b1; acc_write_i = wr; acc_off_i = off; acc_len_i = len; acc_wdata_i = d;
    @(negedge clk);
    acc_valid_i = 1'b0;
    chk({tag, " rsp_valid"}, 32'(rsp_valid_o), 32'd1);
    chk({tag, " rsp_err"}, 32'(rsp_err_o), 32'(err_e));
    chk({tag, " rsp_data"}, rsp_data_o, wr ? 32'h0 : rd_e);
    chk({tag, " R9 io_chg"}, 32'(io_chg_o), 32'(wr_ok && (i == 7 || i == 12)));
    chk({tag, " R9 mem_chg"}, 32'(mem_chg_o), 32'(wr_ok && i == 8));
    if (wr_ok && wable(i)) begin
      m[i] = merge_exp(m[i], d, int'(off[1:0]), (len == 2'd0) ? 1 : (len == 2'd1) ? 2 : 4);
      if (i == 7) m[i] = m[i] | 32'h0000_0101;
    end
    chk({tag, " R8 sec_bus"}, 32'(sec_bus_o), 32'(m[6][15:8]));
    chk({tag, " R6 io_win"}, 32'(io_win_o), 32'(m[7][15:0]));
    chk({tag, " R3 windows"}, mem_win_o ^ pref_win_o ^ io_upper_o ^ pref_base_hi_o ^ pref_lim_hi_o,
        m[8] ^ m[9] ^ m[12] ^ m[10] ^ m[11]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; acc_valid_i = 1'b0; acc_write_i = 1'b0;
    acc_off_i = '0; acc_len_i = '0; acc_wdata_i = '0;
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset contents of every dword
    for (int i = 0; i < 16; i++) acc("R1", 1'b0, 8'(i * 4), 2'd2, 32'h0);

    // R2 / R8 bus numbers
    acc("R2", 1'b1, 8'h18, 2'd2, 32'hA1B2_C3D4);
    acc("R2", 1'b0, 8'h18, 2'd2, 32'h0);
    // R2 / R6 I/O dword with type bits cleared
    acc("R6", 1'b1, 8'h1C, 2'd2, 32'h5566_F0E0);
    acc("R6", 1'b0, 8'h1C, 2'd2, 32'h0);
    acc("R6", 1'b1, 8'h1D, 2'd0, 32'h0000_0020);
    acc("R6", 1'b0, 8'h1C, 2'd0, 32'h0);
    // R3 windows and upper fields, ROM reads zero
    acc("R3", 1'b1, 8'h20, 2'd2, 32'h3450_1230);
    acc("R3", 1'b1, 8'h24, 2'd2, 32'h7FF1_4001);
    acc("R3", 1'b1, 8'h28, 2'd2, 32'h0000_0011);
    acc("R3", 1'b1, 8'h2C, 2'd2, 32'h0000_0022);
    acc("R3", 1'b1, 8'h30, 2'd2, 32'hBEEF_CAFE);
    for (int i = 8; i <= 12; i++) acc("R3", 1'b0, 8'(i * 4), 2'd2, 32'h0);
    acc("R3", 1'b0, 8'h38, 2'd2, 32'h0);
    // R5 partial writes
    acc("R5", 1'b1, 8'h19, 2'd0, 32'hFFFF_FF77);
    acc("R5", 1'b0, 8'h18, 2'd2, 32'h0);
    acc("R5", 1'b1, 8'h22, 2'd1, 32'hAAAA_1234);
    acc("R5", 1'b0, 8'h20, 2'd2, 32'h0);
    acc("R5", 1'b1, 8'h13, 2'd1, 32'h0000_BB99);
    acc("R5", 1'b0, 8'h10, 2'd2, 32'h0);
    acc("R5", 1'b1, 8'h1F, 2'd0, 32'h0000_005A);
    acc("R5", 1'b0, 8'h1E, 2'd2, 32'h0);
    // R7 read-only dwords
    acc("R7", 1'b1, 8'h00, 2'd2, 32'hFFFF_FFFF);
    acc("R7", 1'b1, 8'h08, 2'd2, 32'hFFFF_FFFF);
    acc("R7", 1'b1, 8'h0C, 2'd0, 32'h0000_00FF);
    acc("R7", 1'b1, 8'h38, 2'd2, 32'hFFFF_FFFF);
    for (int i = 0; i < 4; i++) acc("R7", 1'b0, 8'(i * 4), 2'd2, 32'h0);
    acc("R7", 1'b0, 8'h38, 2'd2, 32'h0);
    // R4 unmapped offsets
    acc("R4", 1'b0, 8'h34, 2'd2, 32'h0);
    acc("R4", 1'b0, 8'h3C, 2'd2, 32'h0);
    acc("R4", 1'b0, 8'h40, 2'd2, 32'h0);
    acc("R4", 1'b0, 8'hFC, 2'd2, 32'h0);
    acc("R4", 1'b1, 8'h34, 2'd2, 32'h1234_5678);
    acc("R4", 1'b1, 8'h80, 2'd2, 32'h1234_5678);
    // R10 bad length write, read ignoring low bits and length
    acc("R10", 1'b1, 8'h20, 2'd3, 32'hDEAD_BEEF);
    acc("R10", 1'b0, 8'h23, 2'd3, 32'h0);
    acc("R10", 1'b1, 8'h04, 2'd2, 32'h0000_0007);
    acc("R10", 1'b0, 8'h05, 2'd0, 32'h0);

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      logic [7:0] off = 8'($urandom_range(0, 8'h4F));
      acc("R5 rand", 1'($urandom_range(0, 1)), off, 2'($urandom_range(0, 3)), $urandom);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule